// File: doc/BRIEF.md
# Interrupt Flag and Wake Controller

This block collects three interrupt sources for a small 8-bit core: an external pin whose active edge is picked at run time, a rollover of an 8-bit counter, and any change on a 4-bit slice of an I/O port. Each source sets its own sticky flag in an 8-bit control register. The same register holds the per-source enables and a global enable. The core reads and writes the register over a simple register port. A separate one-bit register selects the pin edge.

Two request outputs come from the register. The wake output rises whenever any flag is set together with its own enable, whatever the global enable holds. A sleeping core uses it to resume. The vector request also needs the global enable. When the core accepts the vector it pulses an acknowledge, and that clears the global enable. The pin and the port slice pass through a two-stage synchroniser before detection. The port slice is compared with a reference copy that is loaded each time software reads the port.

Top module: `irq_ctl_top`

## Requirements
- R1: After reset the control register reads 0x00, the edge-select register reads 1, and both request outputs are 0.
- R2: With edge select 1, a low-to-high change on the pin sets control bit 1 at the third rising clock edge after the change. A high-to-low change leaves bit 1 unchanged.
- R3: With edge select 0, a high-to-low change on the pin sets control bit 1. A low-to-high change leaves bit 1 unchanged.
- R4: A counter input that goes from 0xFF in one cycle to 0x00 in the next sets control bit 2 at the following edge. Other transitions into 0x00, such as from 0xFE, leave bit 2 unchanged.
- R5: While the synchronised port slice differs from the reference copy, control bit 0 is set. A one-cycle pulse on port_rd loads the reference from the synchronised slice. After that, a written clear of bit 0 holds until the slice changes again.
- R6: Flags (bits 2..0) are set whatever the enables hold. Only a register write clears a flag, and a flag stays set for any number of cycles without one.
- R7: When a source sets a flag in the same cycle that a write clears it, the flag ends up set.
- R8: wake_req is 1 exactly when at least one of the pairs holds: bit 0 with enable bit 3, bit 1 with enable bit 4, or bit 2 with enable bit 5. Bits 6 and 7 have no effect on it.
- R9: irq_req equals wake_req ANDed with the global enable, bit 7.
- R10: A pulse on vec_ack clears bit 7 at the next edge, even when a write of 1 to bit 7 happens in the same cycle.
- R11: A write on the register port loads all eight bits, and reg_rdata returns them at the next edge. A write on the edge-select port loads that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ext_pin | input | 1 | External interrupt pin, asynchronous |
| port_in | input | PW (4) | Monitored port slice, asynchronous |
| port_rd | input | 1 | Software port read strobe; loads the change reference |
| tmr_cnt | input | TW (8) | Current count of the 8-bit timer |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register contents |
| esel_wr | input | 1 | Edge-select write strobe |
| esel_wdata | input | 1 | Edge-select write data (1 rising, 0 falling) |
| esel_q | output | 1 | Current edge select |
| vec_ack | input | 1 | Core accepted the interrupt vector |
| irq_req | output | 1 | Vector request |
| wake_req | output | 1 | Wake-from-sleep request |

## Verification
Pin and port changes pass two synchroniser stages and one flag register, so their flag is due at the third rising edge after the input moves. A counter wrap shows one edge after the 0x00 sample, and a register write or acknowledge shows one edge after its strobe. The request outputs follow the register in the same cycle. The bench drives every input on a falling edge and counts rising edges to the due one. It samples on the next falling edge, and for the pin it also checks one edge early that the flag is not yet set.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;
  localparam int CTRL_W   = 8;
  localparam int NSRC     = 3;  // 0 port change, 1 external pin, 2 timer wrap
  localparam int FLAG_LSB = 0;  // flags occupy bits 2..0
  localparam int EN_LSB   = 3;  // matching enables occupy bits 5..3
  localparam int GLOB_BIT = 7;
  localparam logic ESEL_RST = 1'b1;

  typedef logic [NSRC-1:0] src_vec_t;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/irq_ext_edge.sv
module irq_ext_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_s,
  input  logic rise_sel,
  output logic hit
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= pin_s;
  end

  always_comb begin
    if (rise_sel) hit = pin_s & ~prev_q;
    else          hit = ~pin_s & prev_q;
  end

  // R2
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit && $stable(rise_sel) |=> !hit);
endmodule

// File: rtl/irq_port_chg.sv
module irq_port_chg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] port_s,
  input  logic         snap,
  output logic         diff
);
  logic [W-1:0] ref_q, ref_d;

  always_comb begin
    ref_d = ref_q;
    if (snap) ref_d = port_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ref_q <= '0;
    else if (snap) ref_q <= ref_d;
  end

  assign diff = |(port_s ^ ref_q);

  // R5
  ref_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snap |=> (ref_q == $past(port_s)));
endmodule

// File: rtl/irq_ctrl_reg.sv
module irq_ctrl_reg
  import irq_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  src_vec_t          src_set,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              vec_ack,
  input  logic              esel_wr,
  input  logic              esel_wdata,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic              esel_q,
  output logic              wake,
  output logic              irq
);
  logic [CTRL_W-1:0] ctrl_d;
  logic              ctrl_en;
  src_vec_t          pend;

  // Priority: write, then acknowledge on the global bit, then hardware sets.
  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_en)   ctrl_d = wr_data;
    if (vec_ack) ctrl_d[GLOB_BIT] = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (src_set[i]) ctrl_d[FLAG_LSB+i] = 1'b1;
    end
  end

  assign ctrl_en = wr_en | vec_ack | (|src_set);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_en) ctrl_q <= ctrl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       esel_q <= ESEL_RST;
    else if (esel_wr) esel_q <= esel_wdata;
  end

  genvar g;
  generate
    for (g = 0; g < NSRC; g++) begin : g_src
      assign pend[g] = ctrl_q[FLAG_LSB+g] & ctrl_q[EN_LSB+g];

      // R7
      set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        src_set[g] |=> ctrl_q[FLAG_LSB+g]);

      // R6
      flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[FLAG_LSB+g] && !wr_en |=> ctrl_q[FLAG_LSB+g]);
    end
  endgenerate

  assign wake = |pend;
  assign irq  = wake & ctrl_q[GLOB_BIT];

  // R10
  gie_ack_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_ack |=> !ctrl_q[GLOB_BIT]);

  // R11
  esel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    esel_wr |=> (esel_q == $past(esel_wdata)));
endmodule

// File: rtl/irq_ctl_top.sv
module irq_ctl_top
  import irq_ctl_pkg::*;
#(
  parameter int PW          = 4,
  parameter int TW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_pin,
  input  logic [PW-1:0]     port_in,
  input  logic              port_rd,
  input  logic [TW-1:0]     tmr_cnt,
  input  logic              reg_wr,
  input  logic [CTRL_W-1:0] reg_wdata,
  output logic [CTRL_W-1:0] reg_rdata,
  input  logic              esel_wr,
  input  logic              esel_wdata,
  output logic              esel_q,
  input  logic              vec_ack,
  output logic              irq_req,
  output logic              wake_req
);
  localparam int RST_STAGES = 2;
  localparam logic [TW-1:0] TMR_TOP = {TW{1'b1}};

  // Reset: asserted asynchronously, released on the clock.
  logic [RST_STAGES-1:0] rst_pipe_q;
  logic                  rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[RST_STAGES-2:0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[RST_STAGES-1];

  logic          pin_s;
  logic [PW-1:0] port_s;
  logic          ext_hit, port_diff, tmr_wrap;
  logic [TW-1:0] tmr_prev_q;
  src_vec_t      src_set;

  irq_sync #(.W(1), .STAGES(SYNC_STAGES)) u_pin_sync (
    .clk(clk), .rst_n(rst_core_n), .d(ext_pin), .q(pin_s));

  irq_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_port_sync (
    .clk(clk), .rst_n(rst_core_n), .d(port_in), .q(port_s));

  irq_ext_edge u_edge (
    .clk(clk), .rst_n(rst_core_n), .pin_s(pin_s), .rise_sel(esel_q), .hit(ext_hit));

  irq_port_chg #(.W(PW)) u_chg (
    .clk(clk), .rst_n(rst_core_n), .port_s(port_s), .snap(port_rd), .diff(port_diff));

  // Timer rollover: top count seen last cycle, zero now.
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) tmr_prev_q <= '0;
    else             tmr_prev_q <= tmr_cnt;
  end
  assign tmr_wrap = (tmr_prev_q == TMR_TOP) && (tmr_cnt == '0);

  assign src_set = {tmr_wrap, ext_hit, port_diff};

  irq_ctrl_reg u_reg (
    .clk(clk), .rst_n(rst_core_n), .src_set(src_set),
    .wr_en(reg_wr), .wr_data(reg_wdata), .vec_ack(vec_ack),
    .esel_wr(esel_wr), .esel_wdata(esel_wdata),
    .ctrl_q(reg_rdata), .esel_q(esel_q), .wake(wake_req), .irq(irq_req));

  // R4
  wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    tmr_wrap |=> reg_rdata[2]);

  // R9
  irq_needs_wake_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    !wake_req |-> !irq_req);
endmodule

// File: tb/irq_ctl_top_tb.sv
`timescale 1ns/1ps
module irq_ctl_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ext_pin;
  logic [3:0] port_in;
  logic       port_rd;
  logic [7:0] tmr_cnt;
  logic       reg_wr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       esel_wr, esel_wdata, esel_q;
  logic       vec_ack, irq_req, wake_req;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  irq_ctl_top dut_i (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .port_in(port_in),
    .port_rd(port_rd), .tmr_cnt(tmr_cnt), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .esel_wr(esel_wr),
    .esel_wdata(esel_wdata), .esel_q(esel_q), .vec_ack(vec_ack),
    .irq_req(irq_req), .wake_req(wake_req));

  // {write value, expected wake_req, expected irq_req}
  localparam logic [9:0] VEC [11] = '{
    {8'h00, 1'b0, 1'b0},
    {8'h01, 1'b0, 1'b0},
    {8'h09, 1'b1, 1'b0},
    {8'h89, 1'b1, 1'b1},
    {8'h12, 1'b1, 1'b0},
    {8'h92, 1'b1, 1'b1},
    {8'hA4, 1'b1, 1'b1},
    {8'h24, 1'b1, 1'b0},
    {8'hB8, 1'b0, 1'b0},
    {8'h84, 1'b0, 1'b0},
    {8'hCA, 1'b0, 1'b0}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ctrl_write(input logic [7:0] v);
    @(negedge clk);
    reg_wr = 1'b1; reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ext_pin = 1'b0; port_in = 4'h0; port_rd = 1'b0;
    tmr_cnt = 8'h00; reg_wr = 1'b0; reg_wdata = 8'h00;
    esel_wr = 1'b0; esel_wdata = 1'b0; vec_ack = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(4);

    // R1 reset state
    chk("R1 ctrl", reg_rdata, 8'h00);
    chk("R1 esel", {7'd0, esel_q}, 8'h01);
    chk("R1 req", {6'd0, wake_req, irq_req}, 8'h00);

    // R8 R9 R11 table walk
    for (int i = 0; i < 11; i++) begin
      ctrl_write(VEC[i][9:2]);
      chk("R11 readback", reg_rdata, VEC[i][9:2]);
      chk("R8 wake", {7'd0, wake_req}, {7'd0, VEC[i][1]});
      chk("R9 irq", {7'd0, irq_req}, {7'd0, VEC[i][0]});
    end
    ctrl_write(8'h00);

    // R2 rising edge selected
    ext_pin = 1'b1;
    tick(2);
    chk("R2 not yet", {7'd0, reg_rdata[1]}, 8'h00);
    tick(1);
    chk("R2 rise sets", {7'd0, reg_rdata[1]}, 8'h01);
    ctrl_write(8'h00);
    ext_pin = 1'b0;
    tick(4);
    chk("R2 fall ignored", {7'd0, reg_rdata[1]}, 8'h00);

    // R3 falling edge selected
    @(negedge clk); esel_wr = 1'b1; esel_wdata = 1'b0;
    @(negedge clk); esel_wr = 1'b0;
    chk("R11 esel write", {7'd0, esel_q}, 8'h00);
    ext_pin = 1'b1;
    tick(4);
    chk("R3 rise ignored", {7'd0, reg_rdata[1]}, 8'h00);
    ext_pin = 1'b0;
    tick(3);
    chk("R3 fall sets", {7'd0, reg_rdata[1]}, 8'h01);

    // R6 sticky without enables, cleared only by write
    tick(6);
    chk("R6 sticky", reg_rdata, 8'h02);
    ctrl_write(8'h00);
    chk("R6 write clears", reg_rdata, 8'h00);

    // R4 timer wrap
    @(negedge clk); tmr_cnt = 8'hFE;
    @(negedge clk); tmr_cnt = 8'h00;
    @(negedge clk);
    chk("R4 FE->00 ignored", {7'd0, reg_rdata[2]}, 8'h00);
    tmr_cnt = 8'hFF;
    @(negedge clk); tmr_cnt = 8'h00;
    @(negedge clk);
    chk("R4 FF->00 sets", {7'd0, reg_rdata[2]}, 8'h01);
    ctrl_write(8'h00);

    // R7 set beats clear in the same cycle
    @(negedge clk); tmr_cnt = 8'hFF;
    @(negedge clk); tmr_cnt = 8'h00; reg_wr = 1'b1; reg_wdata = 8'h00;
    @(negedge clk); reg_wr = 1'b0;
    chk("R7 set wins", {7'd0, reg_rdata[2]}, 8'h01);
    ctrl_write(8'h00);
    chk("R7 cleared after", reg_rdata, 8'h00);

    // R5 port change against reference
    port_in = 4'h5;
    tick(3);
    chk("R5 change sets", {7'd0, reg_rdata[0]}, 8'h01);
    ctrl_write(8'h00);
    chk("R5 mismatch keeps flag", {7'd0, reg_rdata[0]}, 8'h01);
    @(negedge clk); port_rd = 1'b1;
    @(negedge clk); port_rd = 1'b0;
    ctrl_write(8'h00);
    chk("R5 clear after read", {7'd0, reg_rdata[0]}, 8'h00);
    tick(4);
    chk("R5 stays clear", {7'd0, reg_rdata[0]}, 8'h00);
    port_in = 4'h4;
    tick(3);
    chk("R5 new change sets", {7'd0, reg_rdata[0]}, 8'h01);

    // R8 R9 R10 wake without global enable, acknowledge
    ctrl_write(8'h09);
    chk("R8 wake no gie", {6'd0, wake_req, irq_req}, 8'h02);
    ctrl_write(8'h89);
    chk("R9 irq with gie", {6'd0, wake_req, irq_req}, 8'h03);
    @(negedge clk); vec_ack = 1'b1;
    @(negedge clk); vec_ack = 1'b0;
    chk("R10 ack clears gie", reg_rdata, 8'h09);
    chk("R10 wake kept", {6'd0, wake_req, irq_req}, 8'h02);
    @(negedge clk); vec_ack = 1'b1; reg_wr = 1'b1; reg_wdata = 8'h89;
    @(negedge clk); vec_ack = 1'b0; reg_wr = 1'b0;
    chk("R10 ack beats write", reg_rdata, 8'h09);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule